// File: doc/BRIEF.md
# Dual Cascaded Interval Timer with Host Interrupt Latch

This block provides two free-running periodic timers and the small interrupt controller that turns their expiries, together with three external request pulses, into one interrupt line for a host processor. Each timer is two down-counters in cascade. The first counter counts a prescale value down to zero. Each time it wraps, the second counter steps by one. When both counters reach zero in the same cycle, the period ends, the timer raises a one-cycle tick, and both counters reload. A period therefore lasts (prescale + 1) × (divide + 1) clock cycles.

The host reaches the block through a 16-bit word bus with byte enables. The period registers can only be written. The live counter values are read at a separate group of read-only offsets. An interrupt control word holds five enable bits in its low byte. Writing a one to a bit of its high byte clears the matching pending latch. Reading the word returns the pending latches. The host interrupt output is high while any latch is set.

Top module: `pit_pair_irq`

## Requirements
- R1: Each timer ticks once every (P+1)×(D+1) clock cycles, where P is its prescale register and D is its divide register, and it reloads by itself after every tick.
- R2: After reset, all four period registers hold 0xFFFF, both timers' live counts read 0xFFFF, and the enable and pending bits are all zero.
- R3: Writes go to byte offsets 0x00 (timer 1 prescale), 0x02 (timer 1 divide), 0x04 (timer 2 prescale) and 0x06 (timer 2 divide). be_i[0] updates bits 7:0 and be_i[1] updates bits 15:8. These offsets read back as zero.
- R4: Offsets 0x36 and 0x38 return timer 1's live prescale and divide counts. Offsets 0x3A and 0x3C return the same counts for timer 2. The prescale count runs down from P to 0. When it wraps, the divide count steps down from D. Any offset not named here reads as zero.
- R5: The interrupt control word sits at offset 0x20. Enable bits are written through its low byte: bit 0 external, bit 1 timer 1, bit 2 timer 2, bit 3 asynchronous serial, bit 4 synchronous serial.
- R6: A write with be_i[1] set clears every pending latch whose bit is one in wdata_i[12:8], using the same source order as R5. A read of offset 0x20 returns the pending latches in bits 4:0.
- R7: A source sets its pending latch at the clock edge where it is high only if its enable bit is one. Its effect shows on irq_o and in the readback one cycle after the request.
- R8: irq_o is the OR of all pending latches. It stays high until every pending latch has been cleared.
- R9: The counters run at all times, whatever the enable bits hold.
- R10: Writing a timer's prescale or divide register reloads both of that timer's counters with the new register values at the same edge.
- R11: When a source sets a latch in the same cycle that software clears it, the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the current bus cycle |
| be_i | input | 2 | Byte enables; bit 1 selects bits 15:8 |
| waddr_i | input | 5 | Word offset (byte offset divided by two) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for waddr_i, combinational |
| ext_req_i | input | 1 | External interrupt request pulse |
| async_req_i | input | 1 | Asynchronous serial port request pulse |
| sync_req_i | input | 1 | Synchronous serial port request pulse |
| irq_o | output | 1 | Combined host interrupt |

## Verification
Every result of this block is due exactly one clock edge after its cause. A register write changes the live counts at the edge that takes it. A tick or an enabled request pulse sets its latch, and raises irq_o, at the edge where the tick or pulse is high. A clear takes effect at the edge of its write. The bench drives inputs just after the falling edge and updates its model on the rising edge. It then compares irq_o and the read data for the current offset at the next falling edge, so each comparison lands in the first cycle the result can appear. Directed reads made just after a write or pulse check the same one-edge latency, and the timer period is measured by counting edges between successive rises of irq_o.

// File: rtl/pit_pair_pkg.sv
package pit_pair_pkg;
  localparam int N_SRC   = 5;
  localparam int SRC_EXT = 0;
  localparam int SRC_T1  = 1;
  localparam int SRC_T2  = 2;
  localparam int SRC_ASY = 3;
  localparam int SRC_SYN = 4;
  // byte offsets; behaviour depends on these
  localparam int OFS_PERIOD = 'h00;  // 4 words: presc/div per timer
  localparam int OFS_ICR    = 'h20;
  localparam int OFS_LIVE   = 'h36;  // 4 words: live presc/div per timer
  localparam int CLR_LSB    = 8;
endpackage

// File: rtl/pit_cascade_timer.sv
module pit_cascade_timer #(
  parameter int W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W/8-1:0]   wr_presc_i,
  input  logic [W/8-1:0]   wr_div_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     presc_o,
  output logic [W-1:0]     div_o,
  output logic [W-1:0]     pcnt_o,
  output logic [W-1:0]     dcnt_o,
  output logic             load_o,
  output logic             tick_o
);
  localparam int NB = W / 8;

  logic [W-1:0] presc_q, div_q, presc_d, div_d, pcnt_q, dcnt_q;

  function automatic logic [W-1:0] merge(input logic [W-1:0] old,
                                         input logic [NB-1:0] be,
                                         input logic [W-1:0] d);
    logic [W-1:0] r;
    r = old;
    for (int b = 0; b < NB; b++)
      if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  always_comb begin
    presc_d = merge(presc_q, wr_presc_i, wdata_i);
    div_d   = merge(div_q, wr_div_i, wdata_i);
  end

  assign load_o = (|wr_presc_i) | (|wr_div_i);
  assign tick_o = (pcnt_q == '0) && (dcnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '1;
      div_q   <= '1;
      pcnt_q  <= '1;
      dcnt_q  <= '1;
    end else begin
      presc_q <= presc_d;
      div_q   <= div_d;
      if (load_o) begin
        pcnt_q <= presc_d;
        dcnt_q <= div_d;
      end else if (pcnt_q == '0) begin
        pcnt_q <= presc_q;
        dcnt_q <= (dcnt_q == '0) ? div_q : dcnt_q - W'(1);
      end else begin
        pcnt_q <= pcnt_q - W'(1);
      end
    end
  end

  assign presc_o = presc_q;
  assign div_o   = div_q;
  assign pcnt_o  = pcnt_q;
  assign dcnt_o  = dcnt_q;
endmodule

// File: rtl/pit_irq_latch.sv
module pit_irq_latch #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_d_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] en_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_wr_i) en_q <= en_d_i;
      // set term last so a same-cycle set beats the clear
      pend_q <= (pend_q & ~clr_i) | (src_i & en_q);
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/pit_pair_irq.sv
module pit_pair_irq
  import pit_pair_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ext_req_i,
  input  logic              async_req_i,
  input  logic              sync_req_i,
  output logic              irq_o
);
  localparam int N_TMR = 2;
  localparam int NB    = DATA_W / 8;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int byte_ofs);
    return a == ADDR_W'(byte_ofs / 2);
  endfunction

  logic [DATA_W-1:0] t_presc [N_TMR];
  logic [DATA_W-1:0] t_div   [N_TMR];
  logic [DATA_W-1:0] t_pcnt  [N_TMR];
  logic [DATA_W-1:0] t_dcnt  [N_TMR];
  logic [N_TMR-1:0]  t_tick, t_load;

  logic [N_SRC-1:0] src_vec, clr_vec, en_q, pend_q;
  logic             icr_hit;

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    logic [NB-1:0] wp, wd;
    assign wp = (wr_i && hit(waddr_i, OFS_PERIOD + 4*t))     ? be_i : '0;
    assign wd = (wr_i && hit(waddr_i, OFS_PERIOD + 4*t + 2)) ? be_i : '0;

    pit_cascade_timer #(.W(DATA_W)) u_tmr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_presc_i (wp),
      .wr_div_i   (wd),
      .wdata_i    (wdata_i),
      .presc_o    (t_presc[t]),
      .div_o      (t_div[t]),
      .pcnt_o     (t_pcnt[t]),
      .dcnt_o     (t_dcnt[t]),
      .load_o     (t_load[t]),
      .tick_o     (t_tick[t])
    );
  end

  assign icr_hit = wr_i && hit(waddr_i, OFS_ICR);

  always_comb begin
    src_vec          = '0;
    src_vec[SRC_EXT] = ext_req_i;
    src_vec[SRC_T1]  = t_tick[0];
    src_vec[SRC_T2]  = t_tick[1];
    src_vec[SRC_ASY] = async_req_i;
    src_vec[SRC_SYN] = sync_req_i;
    clr_vec = (icr_hit && be_i[1]) ? wdata_i[CLR_LSB +: N_SRC] : '0;
  end

  pit_irq_latch #(.N(N_SRC)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src_vec),
    .en_wr_i (icr_hit && be_i[0]),
    .en_d_i  (wdata_i[N_SRC-1:0]),
    .clr_i   (clr_vec),
    .en_o    (en_q),
    .pend_o  (pend_q)
  );

  assign irq_o = |pend_q;

  always_comb begin
    rdata_o = '0;
    if (hit(waddr_i, OFS_ICR)) rdata_o = DATA_W'(pend_q);
    for (int t = 0; t < N_TMR; t++) begin
      if (hit(waddr_i, OFS_LIVE + 4*t))     rdata_o = t_pcnt[t];
      if (hit(waddr_i, OFS_LIVE + 4*t + 2)) rdata_o = t_dcnt[t];
    end
  end
endmodule

// File: rtl/pit_pair_irq_chk.sv
module pit_pair_irq_chk #(
  parameter int W = 16,
  parameter int N = 5
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         irq_o,
  input logic [N-1:0] src_vec,
  input logic [N-1:0] clr_vec,
  input logic [N-1:0] en_q,
  input logic [N-1:0] pend_q,
  input logic         tick0,
  input logic         load0,
  input logic [W-1:0] presc0,
  input logic [W-1:0] div0,
  input logic [W-1:0] pcnt0,
  input logic [W-1:0] dcnt0
);
  a_r1_reload_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick0 && !load0) |=> (pcnt0 == presc0 && dcnt0 == div0));

  a_r10_reload_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load0 |=> (pcnt0 == presc0 && dcnt0 == div0));

  a_r7_no_set_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(~en_q & ~pend_q)) == '0));

  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_vec & en_q) != '0) |=> ((pend_q & $past(src_vec & en_q)) == $past(src_vec & en_q)));

  a_r6_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_vec != '0) |=> ((pend_q & $past(clr_vec & ~(src_vec & en_q))) == '0));

  a_r8_irq_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && clr_vec == '0) |=> irq_o);
endmodule

bind pit_pair_irq pit_pair_irq_chk #(.W(DATA_W), .N(pit_pair_pkg::N_SRC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .src_vec (src_vec),
  .clr_vec (clr_vec),
  .en_q    (en_q),
  .pend_q  (pend_q),
  .tick0   (t_tick[0]),
  .load0   (t_load[0]),
  .presc0  (t_presc[0]),
  .div0    (t_div[0]),
  .pcnt0   (t_pcnt[0]),
  .dcnt0   (t_dcnt[0])
);

// File: tb/pit_pair_irq_test.sv
`timescale 1ns/1ps
module pit_pair_irq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [1:0]  be_i = '0;
  logic [4:0]  waddr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        ext_req_i = 1'b0, async_req_i = 1'b0, sync_req_i = 1'b0;
  logic        irq_o;

  int checks = 0, fails = 0;
  longint cyc = 0;

  always #5 clk_i = ~clk_i;

  pit_pair_irq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .be_i(be_i), .waddr_i(waddr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ext_req_i(ext_req_i),
    .async_req_i(async_req_i), .sync_req_i(sync_req_i), .irq_o(irq_o)
  );

  // behavioural model: phase within period per timer
  longint pr [2], dv [2], ph [2];
  logic [4:0] en_m, pend_m, src_m, clr_m;
  logic       tk [2];

  function automatic logic [15:0] mread(input logic [4:0] wa);
    int a = int'(wa) * 2;
    if (a == 'h20) return {11'd0, pend_m};
    for (int t = 0; t < 2; t++) begin
      if (a == 'h36 + 4*t) return 16'(pr[t] - (ph[t] % (pr[t] + 1)));
      if (a == 'h38 + 4*t) return 16'(dv[t] - (ph[t] / (pr[t] + 1)));
    end
    return 16'h0;
  endfunction

  function automatic longint mrg(input longint old);
    longint r = old;
    if (be_i[0]) r = (r & 'hFF00) | longint'(wdata_i[7:0]);
    if (be_i[1]) r = (r & 'h00FF) | (longint'(wdata_i[15:8]) << 8);
    return r;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < 2; t++) begin pr[t] = 'hFFFF; dv[t] = 'hFFFF; ph[t] = 0; end
      en_m = '0; pend_m = '0;
    end else begin
      cyc++;
      for (int t = 0; t < 2; t++) tk[t] = (ph[t] == (pr[t] + 1) * (dv[t] + 1) - 1);
      src_m = {sync_req_i, async_req_i, tk[1], tk[0], ext_req_i};
      clr_m = (wr_i && waddr_i == 5'h10 && be_i[1]) ? wdata_i[12:8] : '0;
      pend_m = (pend_m & ~clr_m) | (src_m & en_m);
      if (wr_i && waddr_i == 5'h10 && be_i[0]) en_m = wdata_i[4:0];
      for (int t = 0; t < 2; t++) begin
        if (wr_i && waddr_i == 5'(2*t) && be_i != 0) begin pr[t] = mrg(pr[t]); ph[t] = 0; end
        else if (wr_i && waddr_i == 5'(2*t+1) && be_i != 0) begin dv[t] = mrg(dv[t]); ph[t] = 0; end
        else ph[t] = tk[t] ? 0 : ph[t] + 1;
      end
    end
  end

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) if (rst_ni) begin
    int a = int'(waddr_i) * 2;
    string tag = (a == 'h20) ? "R6" : ((a >= 'h36 && a <= 'h3C) ? "R4" : "R3");
    chk(tag, rdata_o, mread(waddr_i));
    chk("R8", irq_o, |pend_m);
  end

  task automatic wr(input int byte_ofs, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk_i); #2;
    wr_i = 1'b1; be_i = be; waddr_i = 5'(byte_ofs / 2); wdata_i = d;
    @(negedge clk_i); #2;
    wr_i = 1'b0; be_i = '0;
  endtask

  task automatic rd(input int byte_ofs, output logic [15:0] v);
    waddr_i = 5'(byte_ofs / 2); #1; v = rdata_o;
  endtask

  task automatic rd_chk(input string tag, input int byte_ofs, input logic [15:0] exp);
    logic [15:0] v;
    rd(byte_ofs, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse(input int which);
    @(negedge clk_i); #2;
    case (which) 0: ext_req_i = 1; 3: async_req_i = 1; default: sync_req_i = 1; endcase
    @(negedge clk_i); #2;
    ext_req_i = 0; async_req_i = 0; sync_req_i = 0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] v0, v1;
    longint c0, c1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R2 reset state
    rd_chk("R2", 'h36, 16'hFFFF);
    rd_chk("R2", 'h3C, 16'hFFFF);
    rd_chk("R2", 'h20, 16'h0000);
    chk("R2", irq_o, 0);

    // R3 / R10: program timer 1, reload seen right after write
    wr('h00, 2'b11, 16'd2);
    rd_chk("R10", 'h36, 16'd2);
    wr('h02, 2'b11, 16'd3);
    rd_chk("R10", 'h38, 16'd3);
    rd_chk("R3", 'h02, 16'h0000);

    // R1: period 3*4 = 12 cycles
    wr('h20, 2'b01, 16'h0002);
    while (!irq_o) begin @(negedge clk_i); #1; end
    c0 = cyc;
    wr('h20, 2'b10, 16'h0200);
    while (!irq_o) begin @(negedge clk_i); #1; end
    c1 = cyc;
    chk("R1", c1 - c0, 12);

    // R11: timer 2 ticks every cycle, clear cannot win
    wr('h04, 2'b11, 16'd0);
    wr('h06, 2'b11, 16'd0);
    wr('h20, 2'b01, 16'h0004);
    repeat (2) @(negedge clk_i);
    wr('h20, 2'b10, 16'h0400);
    rd(('h20), v0);
    chk("R11", v0[2], 1);

    // R7: disabled timer 2 no longer sets
    wr('h20, 2'b01, 16'h0000);
    wr('h20, 2'b10, 16'h1F00);
    rd_chk("R6", 'h20, 16'h0000);
    repeat (5) @(negedge clk_i);
    #2 rd_chk("R7", 'h20, 16'h0000);
    chk("R7", irq_o, 0);

    // R9: counters run with all enables off
    @(negedge clk_i); #2; rd('h36, v0);
    @(negedge clk_i); #2; rd('h36, v1);
    chk("R9", v0 != v1, 1);

    // R7 / R5: external source gated by its enable
    pulse(0);
    chk("R7", irq_o, 0);
    wr('h20, 2'b01, 16'h0019);
    pulse(0);
    chk("R5", irq_o, 1);
    rd_chk("R5", 'h20, 16'h0001);
    pulse(3);
    rd_chk("R5", 'h20, 16'h0009);
    pulse(4);
    rd_chk("R5", 'h20, 16'h0019);

    // R8: irq holds until the last latch clears
    wr('h20, 2'b10, 16'h0900);
    chk("R8", irq_o, 1);
    rd_chk("R6", 'h20, 16'h0010);
    wr('h20, 2'b10, 16'h1000);
    chk("R8", irq_o, 0);

    // R3 byte write: high byte of timer 2 divide only
    wr('h06, 2'b10, 16'h05AA);
    rd_chk("R3", 'h3C, 16'h0500);
    rd_chk("R4", 'h3A, 16'h0000);
    rd_chk("R3", 'h06, 16'h0000);
    repeat (20) @(negedge clk_i);
    summary();
  end
endmodule